// File: doc/BRIEF.md
# Configurable Routing and Logic Cell

This block is one fine-grain programmable cell of a logic fabric. It evaluates a Boolean function of up to three signals and, at the same time, forwards raw signals to its neighbours. Three pins come in: one from the vertical channel (`in_chan`) and two from the local diagonal wires (`in_diag_l`, `in_diag_r`). They feed a 3-input truth table. The table result can be taken directly or after a user-clocked register. Each of the three output pins picks its own source on its own: any raw input pin, or the selected function result. A single cell can therefore act as a plain route-through, a splitter, a function generator, or a mix of these. The stored result can stand in for the `in_diag_r` operand, which turns the cell into a one-bit state machine.

All configuration lives in a 16-bit scan chain with its own clock `cfg_clk` and enable `cfg_en`. The chain has no address decoding. `scan_out` carries the last stage of the chain so that cells can be daisy-chained. The configuration word has the following fields, from most significant bit to least:

- `osel_r` in [15:14]
- `osel_l` in [13:12]
- `osel_c` in [11:10]
- `use_reg` in [9]
- `loop_c` in [8]
- `truth` in [7:0]

Top module: `rcell`

## Requirements
- R1: While `rst_n` is low, the function register and the whole configuration chain clear to zero. With an all-zero configuration, every output equals `in_chan`, and a registered selection reads 0.
- R2: On each rising `cfg_clk` edge with `cfg_en` high, the chain shifts one place toward bit 0 and takes `scan_in` into bit 15. A 16-bit word therefore loads least significant bit first. With `cfg_en` low, the chain keeps its contents.
- R3: `scan_out` equals chain bit 0. After a word is loaded, `scan_out` shows bit 0 of that word, and each further shift presents the next higher bit.
- R4: The combinational function result is `truth[{opC, opB, opA}]`. Here opA is `in_chan`, opB is `in_diag_l`, and opC is `in_diag_r` or the loopback value.
- R5: On each rising `clk` edge with `cfg_en` low, the function register takes the combinational result.
- R6: While `cfg_en` is high, the function register keeps its value across `clk` edges.
- R7: When `use_reg` is 1, the function source seen by the outputs is the register. When it is 0, the function source is the combinational result.
- R8: Each output select field uses a 2-bit code: 00 = `in_chan`, 01 = `in_diag_l`, 10 = `in_diag_r`, 11 = function source. `osel_c` drives `out_chan`, `osel_l` drives `out_diag_l`, and `osel_r` drives `out_diag_r`. Raw routing is not affected by the function being in use.
- R9: When `loop_c` is 1, the register value replaces `in_diag_r` as operand C. The `in_diag_r` pin still routes raw to any output that selects code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the function register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Shift enable; also freezes the function register |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Last chain stage, for daisy-chaining |
| in_chan | input | 1 | Input from the vertical channel |
| in_diag_l | input | 1 | First diagonal input |
| in_diag_r | input | 1 | Second diagonal input (loopback-capable operand) |
| out_chan | output | 1 | Output to the vertical channel |
| out_diag_l | output | 1 | First diagonal output |
| out_diag_r | output | 1 | Second diagonal output |

## Verification
A corrupted configuration bit shows up at once as a wrong route or a wrong truth-table entry, as soon as the input pattern addresses it. It also comes out of `scan_out` in the shift after its position is reached. A wrong register value appears on a registered output in the cycle after the bad capture. With loopback on, the error then spreads through every later state step, so a toggle sequence exposes it within a cycle or two. A register that fails to hold during configuration shows as a changed output directly after the load.

// File: rtl/rcell_pkg.sv
package rcell_pkg;
    localparam int N_IN    = 3;
    localparam int TT_W    = 1 << N_IN;
    localparam int SEL_W   = 2;
    localparam int LOOP_IX = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_CHAN  = 2'b00,
        SRC_DIAGL = 2'b01,
        SRC_DIAGR = 2'b10,
        SRC_FUNC  = 2'b11
    } src_e;

    typedef struct packed {
        src_e            osel_r;
        src_e            osel_l;
        src_e            osel_c;
        logic            use_reg;
        logic            loop_c;
        logic [TT_W-1:0] truth;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
    parameter int W = 16
) (
    input  logic         cfg_clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] word,
    output logic         sout
);
    logic [W-1:0] stages;

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n)
            stages <= '0;
        else if (shift_en)
            stages <= {sin, stages[W-1:1]};
    end

    assign word = stages;
    assign sout = stages[0];
endmodule

// File: rtl/lut3.sv
module lut3 #(
    parameter int N = 3
) (
    input  logic [(1<<N)-1:0] table_bits,
    input  logic [N-1:0]      idx,
    output logic              y
);
    assign y = table_bits[idx];
endmodule

// File: rtl/route_mux.sv
module route_mux
    import rcell_pkg::*;
(
    input  src_e sel,
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic fn,
    output logic y
);
    always_comb begin
        unique case (sel)
            SRC_CHAN:  y = a;
            SRC_DIAGL: y = b;
            SRC_DIAGR: y = c;
            SRC_FUNC:  y = fn;
            default:   y = a;
        endcase
    end
endmodule

// File: rtl/rcell.sv
module rcell
    import rcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_clk,
    input  logic cfg_en,
    input  logic scan_in,
    output logic scan_out,
    input  logic in_chan,
    input  logic in_diag_l,
    input  logic in_diag_r,
    output logic out_chan,
    output logic out_diag_l,
    output logic out_diag_r
);
    logic [CFG_W-1:0] cfg_word;
    cell_cfg_t        cfg;
    logic [N_IN-1:0]  pins;
    logic [N_IN-1:0]  opnd;
    logic             fn_comb;
    logic             fn_q;
    logic             fn_src;
    src_e             osel [N_IN];
    logic [N_IN-1:0]  outv;

    cfg_chain #(.W(CFG_W)) u_chain (
        .cfg_clk (cfg_clk),
        .rst_n   (rst_n),
        .shift_en(cfg_en),
        .sin     (scan_in),
        .word    (cfg_word),
        .sout    (scan_out)
    );

    assign cfg  = cell_cfg_t'(cfg_word);
    assign pins = {in_diag_r, in_diag_l, in_chan};

    // operand selectors: only operand C may take the stored value
    for (genvar k = 0; k < N_IN; k++) begin : g_opnd
        if (k == LOOP_IX) begin : g_loop
            assign opnd[k] = cfg.loop_c ? fn_q : pins[k];
        end else begin : g_plain
            assign opnd[k] = pins[k];
        end
    end

    lut3 #(.N(N_IN)) u_lut (
        .table_bits(cfg.truth),
        .idx       (opnd),
        .y         (fn_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fn_q <= 1'b0;
        else if (!cfg_en)
            fn_q <= fn_comb;
    end

    assign fn_src = cfg.use_reg ? fn_q : fn_comb;

    assign osel[0] = cfg.osel_c;
    assign osel[1] = cfg.osel_l;
    assign osel[2] = cfg.osel_r;

    for (genvar k = 0; k < N_IN; k++) begin : g_out
        route_mux u_rm (
            .sel(osel[k]),
            .a  (in_chan),
            .b  (in_diag_l),
            .c  (in_diag_r),
            .fn (fn_src),
            .y  (outv[k])
        );
    end

    assign out_chan   = outv[0];
    assign out_diag_l = outv[1];
    assign out_diag_r = outv[2];
endmodule

// File: rtl/rcell_chk.sv
module rcell_chk
    import rcell_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_clk,
    input logic             cfg_en,
    input logic             scan_in,
    input logic             scan_out,
    input logic [CFG_W-1:0] cfg_word,
    input logic             fn_comb,
    input logic             fn_q,
    input logic             in_chan,
    input logic             in_diag_l,
    input logic             in_diag_r,
    input logic             out_chan
);
    p_shift_r2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_en |=> cfg_word[CFG_W-1] == $past(scan_in));

    p_frozen_r2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_word));

    p_scanout_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_en |=> scan_out == $past(cfg_word[1]));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> fn_q == $past(fn_comb));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(fn_q));

    p_regsel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[9] && cfg_word[11:10] == 2'b11) |-> out_chan == fn_q);

    p_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[11:10] == 2'b01) |-> out_chan == in_diag_l);

    p_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[8] && !cfg_word[9] && cfg_word[11:10] == 2'b11)
            |-> out_chan == cfg_word[{fn_q, in_diag_l, in_chan}]);

    p_rawc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[11:10] == 2'b10) |-> out_chan == in_diag_r);
endmodule

bind rcell rcell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_clk  (cfg_clk),
    .cfg_en   (cfg_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .cfg_word (cfg_word),
    .fn_comb  (fn_comb),
    .fn_q     (fn_q),
    .in_chan  (in_chan),
    .in_diag_l(in_diag_l),
    .in_diag_r(in_diag_r),
    .out_chan (out_chan)
);

// File: tb/test_rcell.sv
module test_rcell;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_clk = 1'b0;
    logic cfg_en = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic in_chan = 1'b0, in_diag_l = 1'b0, in_diag_r = 1'b0;
    logic out_chan, out_diag_l, out_diag_r;

    int checks = 0;
    int errors = 0;

    logic [15:0] cfg = 16'h0;   // bench copy of loaded word
    logic        mq  = 1'b0;    // bench copy of the function register

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    rcell i_rcell (
        .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_en(cfg_en),
        .scan_in(scan_in), .scan_out(scan_out),
        .in_chan(in_chan), .in_diag_l(in_diag_l), .in_diag_r(in_diag_r),
        .out_chan(out_chan), .out_diag_l(out_diag_l), .out_diag_r(out_diag_r)
    );

    function automatic logic [15:0] mk(input logic [7:0] tt, input logic lp,
                                       input logic rg, input logic [1:0] sc,
                                       input logic [1:0] sl, input logic [1:0] sr);
        return {sr, sl, sc, rg, lp, tt};
    endfunction

    function automatic logic fcomb(input logic [15:0] w, input logic a,
                                   input logic b, input logic c, input logic q);
        logic cc;
        cc = w[8] ? q : c;
        return w[{cc, b, a}];
    endfunction

    function automatic logic [2:0] mout(input logic [15:0] w, input logic a,
                                        input logic b, input logic c, input logic q);
        logic [2:0] r;
        logic fv;
        fv = w[9] ? q : fcomb(w, a, b, c, q);
        for (int k = 0; k < 3; k++) begin
            case (w[10+2*k +: 2])
                2'b00:   r[k] = a;
                2'b01:   r[k] = b;
                2'b10:   r[k] = c;
                default: r[k] = fv;
            endcase
        end
        return r;
    endfunction

    task automatic check1(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    // advance the bench register model across the edge just seen
    task automatic model_edge();
        if (rst_n && !cfg_en)
            mq = fcomb(cfg, in_chan, in_diag_l, in_diag_r, mq);
    endtask

    task automatic push_now(input string tag);
        item_t it;
        it.exp = mout(cfg, in_chan, in_diag_l, in_diag_r, mq);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic cycle(input logic a, input logic b, input logic c, input string tag);
        @(posedge clk);
        model_edge();
        #1;
        in_chan = a; in_diag_l = b; in_diag_r = c;
        push_now(tag);
    endtask

    task automatic load(input logic [15:0] w);
        @(posedge clk);
        model_edge();
        #1;
        cfg_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            scan_in = w[i];
            #1 cfg_clk = 1'b1;
            #2 cfg_clk = 1'b0;
            #1;
        end
        cfg = w;
        cfg_en = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                check1(out_chan,   it.exp[0], it.tag, "out_chan");
                check1(out_diag_l, it.exp[1], it.tag, "out_diag_l");
                check1(out_diag_r, it.exp[2], it.tag, "out_diag_r");
            end
        end
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: zero configuration routes in_chan everywhere
        cycle(1, 0, 0, "R1");
        cycle(0, 1, 1, "R1");
        cycle(1, 1, 0, "R1");

        // R1 / R6: registered view after load still shows reset value 0
        load(mk(8'hFF, 0, 1, 2'b11, 2'b11, 2'b11));
        check1(scan_out, 1'b1, "R2", "scan_out after load");
        push_now("R6");
        cycle(0, 0, 0, "R5");      // edge captures 1
        cycle(0, 0, 0, "R5");
        // R6: register holds 1 across a whole load with an all-zero table
        load(mk(8'h00, 0, 1, 2'b11, 2'b11, 2'b11));
        push_now("R6");
        cycle(1, 1, 1, "R5");      // edge captures 0

        // R8: pass-through with rotated routes
        load(mk(8'h00, 0, 0, 2'b01, 2'b10, 2'b00));
        cycle(1, 0, 0, "R8");
        cycle(0, 1, 0, "R8");
        cycle(0, 0, 1, "R8");
        cycle(1, 1, 0, "R8");
        // R8: splitter, in_diag_r to all outputs
        load(mk(8'h00, 0, 0, 2'b10, 2'b10, 2'b10));
        cycle(0, 0, 1, "R8");
        cycle(1, 1, 0, "R8");

        // R4: three-input parity and majority, combinational
        load(mk(8'h96, 0, 0, 2'b11, 2'b11, 2'b11));
        for (int p = 0; p < 8; p++) cycle(p[0], p[1], p[2], "R4");
        load(mk(8'hE8, 0, 0, 2'b11, 2'b00, 2'b11));
        for (int p = 0; p < 8; p++) cycle(p[0], p[1], p[2], "R4");

        // R8 hybrid: AND on out_chan, raw pins on the diagonals
        load(mk(8'h80, 0, 0, 2'b11, 2'b00, 2'b01));
        for (int p = 0; p < 8; p++) cycle(p[0], p[1], p[2], "R8");

        // R7: registered parity lags the inputs by one edge
        load(mk(8'h96, 0, 1, 2'b11, 2'b10, 2'b01));
        cycle(1, 0, 0, "R7");
        cycle(1, 1, 0, "R7");
        cycle(1, 1, 1, "R7");
        cycle(0, 0, 0, "R7");

        // R9: toggle state machine, q' = a ^ q, pin C still routes raw
        load(mk(8'h5A, 1, 1, 2'b11, 2'b10, 2'b00));
        cycle(1, 0, 1, "R9");
        cycle(1, 0, 1, "R9");
        cycle(1, 0, 0, "R9");
        cycle(0, 0, 1, "R9");
        cycle(0, 0, 0, "R9");
        cycle(1, 0, 0, "R9");
        // R9: loopback with combinational view
        load(mk(8'h5A, 1, 0, 2'b11, 2'b11, 2'b10));
        cycle(0, 0, 1, "R9");
        cycle(1, 0, 0, "R9");
        cycle(0, 1, 1, "R9");

        // R3: scan_out walks the loaded word LSB first
        load(16'hA5C3);
        check1(scan_out, 1'b1, "R3", "scan_out bit0");
        @(posedge clk);
        model_edge();
        #1 cfg_en = 1'b1;
        for (int i = 1; i < 6; i++) begin
            scan_in = 1'b0;
            #1 cfg_clk = 1'b1;
            #2 cfg_clk = 1'b0;
            #1;
            check1(scan_out, cfg[i], "R3", "scan_out walk");
        end
        cfg = cfg >> 5;
        cfg_en = 1'b0;
        // R2: nothing shifts with enable low
        #1 cfg_clk = 1'b1;
        #2 cfg_clk = 1'b0;
        #1;
        check1(scan_out, cfg[0], "R2", "scan_out frozen");

        // R1: reset clears chain and register
        @(posedge clk);
        model_edge();
        #1 rst_n = 1'b0;
        cfg = 16'h0;
        mq = 1'b0;
        #1;
        check1(scan_out, 1'b0, "R1", "scan_out in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        cycle(0, 1, 1, "R1");
        cycle(1, 0, 1, "R1");

        wait (sbq.size() == 0);
        @(negedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule